// File: doc/BRIEF.md
# Interrupt Vector Address Unit

This block turns a selected exception number into the address of its handler. It keeps a relocatable table base register. When an exception number is accepted, it adds four times that number to the base to form the entry address. It reads one word from that address through a simple request/response memory port. It then presents the returned word to the core as the new program counter, using a valid/ready handshake.

The table base starts at a fixed location in code memory after reset. Software can move it, for example into RAM so that handlers can be swapped at run time. A move is honoured only while the core reports privileged mode. A write made without privilege is dropped, and a one-cycle fault pulse reports it. The low seven bits of the base are always zero. Prioritisation of exceptions, register stacking and the memory contents are handled elsewhere.

Top module: `irq_vector_fetch`

## Requirements
- R1: After reset, base_o is 0x0000_0000, exc_ready_o is 1, and mem_req_o, pc_valid_o and wr_fault_o are all 0.
- R2: While a fetch is in its read phase, mem_addr_o equals the base captured at acceptance plus 4 times the accepted exception number.
- R3: Exception number 17 produces an entry address 0x44 above the base.
- R4: The word returned on mem_rdata_i appears on pc_o with pc_valid_o = 1. Both hold unchanged until pc_ready_i is sampled high, and then pc_valid_o drops.
- R5: A write with priv_i = 1 loads base_wdata_i into the base register with bits 6:0 forced to 0, visible on base_o one cycle later. Without a write, base_o does not change.
- R6: A write with priv_i = 0 leaves base_o unchanged and raises wr_fault_o for exactly one cycle, in the cycle after the write.
- R7: exc_ready_o is 1 only while no fetch is in progress. An exc_valid_i raised during a fetch starts nothing and does not change the running fetch.
- R8: A base write made during a fetch does not alter that fetch's address; the next fetch uses the new base.
- R9: mem_req_o stays high with a stable mem_addr_o until mem_rvalid_i is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 1 | An exception number is offered |
| exc_num_i | input | EXC_W | Selected exception number |
| exc_ready_o | output | 1 | Unit is idle and accepts a number |
| base_wr_i | input | 1 | Write strobe for the table base |
| base_wdata_i | input | ADDR_W | New table base |
| priv_i | input | 1 | Core is in privileged mode |
| base_o | output | ADDR_W | Current table base |
| wr_fault_o | output | 1 | One-cycle pulse after a dropped unprivileged write |
| mem_req_o | output | 1 | Word read request |
| mem_addr_o | output | ADDR_W | Byte address of the table entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | ADDR_W | Word read from the table |
| pc_valid_o | output | 1 | Handler address is valid |
| pc_o | output | ADDR_W | Handler start address |
| pc_ready_i | input | 1 | Core takes the handler address |

## Verification
The assertions assume that the memory answers a request with one mem_rvalid_i pulse and never sends read data when no request is outstanding. The bench's memory model returns data one cycle after it sees a request, and only for that request. The assertions also assume the core does not take back pc_ready_i in a way that matters. The bench holds pc_ready_i low for several cycles to exercise the hold rule and raises it for a single cycle. Exception numbers always fit EXC_W, and the bench drops exc_valid_i before it completes a handshake, so a busy-time offer cannot slip into the next idle cycle.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_DONE = 2'd2
  } fetch_st_e;
endpackage

// File: rtl/ivf_base_reg.sv
module ivf_base_reg #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ALIGN_BITS = 7,
  parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic              priv_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              fault_o
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << ALIGN_BITS) - 64'd1);

  function automatic logic [ADDR_W-1:0] align_base(input logic [ADDR_W-1:0] w);
    return w & ~LOW_MASK;
  endfunction

  logic wr_ok_w, wr_bad_w;
  assign wr_ok_w  = wr_i & priv_i;
  assign wr_bad_w = wr_i & ~priv_i;

  logic [ADDR_W-1:0] base_q;
  logic              fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= align_base(RESET_BASE);
      fault_q <= 1'b0;
    end else begin
      fault_q <= wr_bad_w;
      if (wr_ok_w) base_q <= align_base(wdata_i);
    end
  end

  assign base_o  = base_q;
  assign fault_o = fault_q;

  a_r6_drop_unpriv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_bad_w |=> $stable(base_o) && fault_o);
  a_r6_fault_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_bad_w |=> !fault_o);
  a_r5_write_only_priv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ok_w |=> $stable(base_o));
endmodule

// File: rtl/ivf_fetch_fsm.sv
module ivf_fetch_fsm
  import ivf_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned EXC_W  = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [EXC_W-1:0]  exc_num_i,
  output logic              exc_ready_o,
  input  logic [ADDR_W-1:0] base_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              pc_valid_o,
  output logic [ADDR_W-1:0] pc_o,
  input  logic              pc_ready_i,
  output logic              accept_o,
  output logic              resp_o
);
  localparam int unsigned ENTRY_SHIFT = 2;

  function automatic logic [ADDR_W-1:0] entry_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [EXC_W-1:0]  num);
    return base + (ADDR_W'(num) << ENTRY_SHIFT);
  endfunction

  fetch_st_e         st_q, st_d;
  logic [ADDR_W-1:0] addr_q, pc_q;

  assign accept_o = (st_q == ST_IDLE) && exc_valid_i;
  assign resp_o   = (st_q == ST_READ) && mem_rvalid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (exc_valid_i)  st_d = ST_READ;
      ST_READ: if (mem_rvalid_i) st_d = ST_DONE;
      ST_DONE: if (pc_ready_i)   st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      pc_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept_o) addr_q <= entry_addr(base_i, exc_num_i);
      if (resp_o)   pc_q   <= mem_rdata_i;
    end
  end

  assign exc_ready_o = (st_q == ST_IDLE);
  assign mem_req_o   = (st_q == ST_READ);
  assign mem_addr_o  = addr_q;
  assign pc_valid_o  = (st_q == ST_DONE);
  assign pc_o        = pc_q;

  a_r7_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({exc_ready_o, mem_req_o, pc_valid_o}));
  a_r7_accept_starts_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> mem_req_o);
  a_r9_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));
  a_r4_pc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_valid_o && !pc_ready_i |=> pc_valid_o && $stable(pc_o));
  a_r4_pc_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_valid_o && pc_ready_i |=> !pc_valid_o);
  a_r4_pc_from_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_o |=> pc_o == $past(mem_rdata_i));
endmodule

// File: rtl/irq_vector_fetch.sv
module irq_vector_fetch #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned EXC_W      = 9,
  parameter int unsigned ALIGN_BITS = 7,
  parameter logic [ADDR_W-1:0] RESET_BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              exc_valid_i,
  input  logic [EXC_W-1:0]  exc_num_i,
  output logic              exc_ready_o,
  input  logic              base_wr_i,
  input  logic [ADDR_W-1:0] base_wdata_i,
  input  logic              priv_i,
  output logic [ADDR_W-1:0] base_o,
  output logic              wr_fault_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              pc_valid_o,
  output logic [ADDR_W-1:0] pc_o,
  input  logic              pc_ready_i
);
  logic [ADDR_W-1:0] base_w;
  logic              accept_w, resp_w;

  ivf_base_reg #(
    .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .RESET_BASE(RESET_BASE)
  ) base_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(base_wr_i), .wdata_i(base_wdata_i),
    .priv_i(priv_i), .base_o(base_w), .fault_o(wr_fault_o)
  );

  ivf_fetch_fsm #(.ADDR_W(ADDR_W), .EXC_W(EXC_W)) fetch_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .exc_valid_i(exc_valid_i), .exc_num_i(exc_num_i), .exc_ready_o(exc_ready_o),
    .base_i(base_w),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .pc_valid_o(pc_valid_o), .pc_o(pc_o), .pc_ready_i(pc_ready_i),
    .accept_o(accept_w), .resp_o(resp_w)
  );

  assign base_o = base_w;

  a_r8_addr_fixed_in_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !resp_w |=> $stable(mem_addr_o));
  a_r5_base_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i && priv_i |=> base_o[ALIGN_BITS-1:0] == '0);
  a_r7_busy_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_ready_o |-> !accept_w);
endmodule

// File: tb/irq_vector_fetch_tb_top.sv
module irq_vector_fetch_tb_top;
  localparam int AW = 32;
  localparam int EW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  logic          exc_valid = 0, base_wr = 0, priv = 0, pc_ready = 0;
  logic [EW-1:0] exc_num = '0;
  logic [AW-1:0] base_wdata = '0;
  logic          exc_ready, wr_fault, mem_req, pc_valid;
  logic [AW-1:0] base, mem_addr, pc;
  logic          mem_rvalid;
  logic [AW-1:0] mem_rdata;

  int checks = 0;
  int errors = 0;

  irq_vector_fetch dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .exc_valid_i(exc_valid), .exc_num_i(exc_num), .exc_ready_o(exc_ready),
    .base_wr_i(base_wr), .base_wdata_i(base_wdata), .priv_i(priv),
    .base_o(base), .wr_fault_o(wr_fault),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .pc_valid_o(pc_valid), .pc_o(pc), .pc_ready_i(pc_ready)
  );

  // Table contents are computed from the address; no storage needed.
  function automatic logic [AW-1:0] table_word(input logic [AW-1:0] a);
    return (a * 32'd7) ^ 32'h1234_5001;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req && !mem_rvalid;
      mem_rdata  <= table_word(mem_addr);
    end
  end

  task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_base(input logic [AW-1:0] d, input logic p);
    @(negedge clk);
    base_wr = 1; base_wdata = d; priv = p;
    @(negedge clk);
    base_wr = 0; priv = 0;
  endtask

  // Offer an exception number; returns after the accept edge.
  task automatic offer(input logic [EW-1:0] n);
    @(negedge clk);
    check("R7 ready before offer", AW'(exc_ready), 1);
    exc_valid = 1; exc_num = n;
    @(negedge clk);
    exc_valid = 0;
  endtask

  task automatic finish_fetch(input logic [AW-1:0] exp_addr, input string tag);
    for (int i = 0; i < 8 && !pc_valid; i++) @(negedge clk);
    check({tag, " R4 pc valid"}, AW'(pc_valid), 1);
    check({tag, " R4 pc value"}, pc, table_word(exp_addr));
    @(negedge clk);
    check({tag, " R4 held valid"}, AW'(pc_valid), 1);
    check({tag, " R4 held value"}, pc, table_word(exp_addr));
    pc_ready = 1;
    @(negedge clk);
    pc_ready = 0;
    check({tag, " R4 released"}, AW'(pc_valid), 0);
    check({tag, " R7 idle again"}, AW'(exc_ready), 1);
  endtask

  task automatic t_reset;
    check("R1 base", base, 32'h0);
    check("R1 ready", AW'(exc_ready), 1);
    check("R1 req", AW'(mem_req), 0);
    check("R1 pc_valid", AW'(pc_valid), 0);
    check("R1 fault", AW'(wr_fault), 0);
  endtask

  task automatic t_fetch(input logic [EW-1:0] n, input string tag);
    logic [AW-1:0] exp_addr;
    exp_addr = base + AW'(n) * 4;
    offer(n);
    check({tag, " R2 req"}, AW'(mem_req), 1);
    check({tag, " R2 addr"}, mem_addr, exp_addr);
    finish_fetch(exp_addr, tag);
  endtask

  task automatic t_seventeen;
    logic [AW-1:0] b0;
    b0 = base;
    offer(9'd17);
    check("R3 offset 0x44", mem_addr - b0, 32'h44);
    finish_fetch(b0 + 32'h44, "R3");
  endtask

  task automatic t_priv_write;
    write_base(32'h2000_00FF, 1'b1);
    check("R5 aligned base", base, 32'h2000_0080);
    check("R5 no fault", AW'(wr_fault), 0);
    @(negedge clk);
    check("R5 base steady", base, 32'h2000_0080);
  endtask

  task automatic t_unpriv_write;
    logic [AW-1:0] b0;
    b0 = base;
    write_base(32'h0800_0000, 1'b0);
    check("R6 base kept", base, b0);
    check("R6 fault pulse", AW'(wr_fault), 1);
    @(negedge clk);
    check("R6 pulse one cycle", AW'(wr_fault), 0);
    check("R6 base still kept", base, b0);
  endtask

  task automatic t_busy_offer;
    logic [AW-1:0] exp_addr;
    exp_addr = base + 32'd12;
    offer(9'd3);
    exc_valid = 1; exc_num = 9'd40;
    @(negedge clk);
    check("R7 not ready while busy", AW'(exc_ready), 0);
    check("R7 addr unchanged", mem_addr, exp_addr);
    for (int i = 0; i < 8 && !pc_valid; i++) @(negedge clk);
    exc_valid = 0;
    finish_fetch(exp_addr, "R7");
    @(negedge clk);
    check("R7 no stray fetch", AW'(mem_req), 0);
  endtask

  task automatic t_write_during_fetch;
    logic [AW-1:0] old_addr;
    old_addr = base + 32'd20;
    offer(9'd5);
    base_wr = 1; base_wdata = 32'h1000_0000; priv = 1;
    @(negedge clk);
    base_wr = 0; priv = 0;
    check("R8 addr kept during fetch", mem_addr, old_addr);
    check("R9 req held", AW'(mem_req | pc_valid), 1);
    finish_fetch(old_addr, "R8 old");
    check("R8 new base", base, 32'h1000_0000);
    t_fetch(9'd5, "R8 next");
  endtask

  initial begin
    #200000ns;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fetch(9'd0, "R2 n0");
    t_seventeen();
    t_priv_write();
    t_fetch(9'd255, "R2 n255");
    t_seventeen();
    t_unpriv_write();
    t_busy_offer();
    t_write_during_fetch();
    t_fetch(9'd511, "R2 n511");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule